// File: doc/BRIEF.md
# Remote DMA Host Data Port

This block gives a host processor byte- or word-wide access to a network controller's local packet memory through one data port. Software loads a start address and a byte count through byte-wide register writes, then reads or writes the data port repeatedly. Each access moves data at the current address, advances the address and lowers the count. The address wraps from the end of a receive ring back to its first page. When the count runs out, a remote-DMA-complete flag in an interrupt status register is set.

The block also holds the interrupt status and mask registers and drives the interrupt line. The packet memory is an inferred RAM. It sits in a window of the local address space that starts at 16 KB. Its size is a parameter: a full build uses 32 KB, and the default is 4 KB to keep elaboration small. Transmit and receive engines are not part of this block.

Top module: `rdma_port`

## Requirements
- R1: After reset the interrupt status reads 0x80 and every other register reads 0. The interrupt output is low.
- R2: A write to the command register (offset 0) with bit 0 (halt) clear clears status bit 7. A command write with bit 0 set leaves bit 7 as it was.
- R3: Each register is loaded one byte at a time. The offsets are: 1 and 2 for the address low and high bytes, 3 and 4 for the count low and high bytes, 5 for the ring first page, 6 for the ring end page, 7 for status, 8 for mask and 9 for configuration (bit 0 selects word mode). Reading offsets 1 to 4 returns the current address and count.
- R4: In byte mode, each data-port access transfers one byte at the current address and moves the address by 1. A read returns the byte in bits [7:0], with bits [15:8] zero.
- R5: In word mode, each access ignores address bit 0, transfers 16 bits little-endian (the low byte at the even address) and moves the address by 2.
- R6: After an access moves the address, an address equal to end page × 256 is replaced by first page × 256.
- R7: If the count is at most the transfer size, an access sets the count to 0 and sets status bit 6. Otherwise the access lowers the count by the transfer size.
- R8: A command write with halt clear and bit 1 (remote read) or bit 2 (remote write) set, made while the count is 0, sets status bit 6 at once. A command write with halt set, or with neither request bit set, does not set status bit 6.
- R9: The memory answers only when the access address lies in the window from 0x4000 up to 0x4000 plus the window size. A read outside the window returns 0xFFFF and still advances the address and count. A write outside the window is dropped and leaves the address and count unchanged.
- R10: A write to status clears each bit in [6:0] where the written data has a 1. Bit 7 is not affected by this write. A status bit that is set and cleared in the same cycle ends up set.
- R11: The interrupt output is high exactly when status AND mask AND 0x7F is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| dp_rd | input | 1 | Data port read strobe, one access per cycle |
| dp_wr | input | 1 | Data port write strobe, one access per cycle |
| dp_wdata | input | 16 | Data port write data |
| dp_rdata | output | 16 | Data port read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
A wrong address register first shows up at the data port: a read returns another byte, or the wrap lands one step early or late. The address readback also shows the error in the cycle after the access. A count that is off by one sets the completion flag one access too early or too late, and the interrupt line shows this in the same cycle as the flag. The bench keeps a behavioural model with a byte array and integer pointers. It compares the interrupt line with the model on every clock and compares every read against the model.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  typedef enum logic [3:0] {
    RA_CMD      = 4'h0,
    RA_SA_LO    = 4'h1,
    RA_SA_HI    = 4'h2,
    RA_CNT_LO   = 4'h3,
    RA_CNT_HI   = 4'h4,
    RA_PG_FIRST = 4'h5,
    RA_PG_END   = 4'h6,
    RA_INT_STAT = 4'h7,
    RA_INT_MASK = 4'h8,
    RA_DCFG     = 4'h9
  } rdma_reg_e;

  localparam int CMD_HALT = 0;
  localparam int CMD_RREQ = 1;
  localparam int CMD_WREQ = 2;

  localparam int IS_RDC = 6;
  localparam int IS_RST = 7;
endpackage

// File: rtl/rdma_cfg.sv
module rdma_cfg
  import rdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] cmd_q,
  output logic [7:0] first_pg_q,
  output logic [7:0] end_pg_q,
  output logic [7:0] mask_q,
  output logic       word_mode_q
);
  logic [7:0] cmd_d, first_pg_d, end_pg_d, mask_d;
  logic       word_mode_d;

  always_comb begin
    cmd_d       = cmd_q;
    first_pg_d  = first_pg_q;
    end_pg_d    = end_pg_q;
    mask_d      = mask_q;
    word_mode_d = word_mode_q;
    if (reg_we) begin
      case (reg_addr)
        RA_CMD:      cmd_d       = reg_wdata;
        RA_PG_FIRST: first_pg_d  = reg_wdata;
        RA_PG_END:   end_pg_d    = reg_wdata;
        RA_INT_MASK: mask_d      = reg_wdata;
        RA_DCFG:     word_mode_d = reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q       <= '0;
      first_pg_q  <= '0;
      end_pg_q    <= '0;
      mask_q      <= '0;
      word_mode_q <= 1'b0;
    end else begin
      cmd_q       <= cmd_d;
      first_pg_q  <= first_pg_d;
      end_pg_q    <= end_pg_d;
      mask_q      <= mask_d;
      word_mode_q <= word_mode_d;
    end
  end
endmodule

// File: rtl/rdma_ptr.sv
module rdma_ptr #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_mode,
  input  logic          adv,
  input  logic          sa_lo_we,
  input  logic          sa_hi_we,
  input  logic          cnt_lo_we,
  input  logic          cnt_hi_we,
  input  logic [7:0]    wdata,
  input  logic [7:0]    first_pg,
  input  logic [7:0]    end_pg,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] cnt_q,
  output logic          done
);
  logic [AW-1:0] addr_d, addr_sum, first_base, end_base, astep;
  logic [CW-1:0] cnt_d, cstep;

  assign astep      = {{(AW-2){1'b0}}, word_mode, ~word_mode};
  assign cstep      = {{(CW-2){1'b0}}, word_mode, ~word_mode};
  assign first_base = {{(AW-16){1'b0}}, first_pg, 8'h00};
  assign end_base   = {{(AW-16){1'b0}}, end_pg, 8'h00};
  assign addr_sum   = addr_q + astep;
  assign done       = adv && (cnt_q <= cstep);

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    if (adv) begin
      addr_d = (addr_sum == end_base) ? first_base : addr_sum;
      cnt_d  = done ? '0 : (cnt_q - cstep);
    end
    if (sa_lo_we)  addr_d[7:0]  = wdata;
    if (sa_hi_we)  addr_d[15:8] = wdata;
    if (cnt_lo_we) cnt_d[7:0]   = wdata;
    if (cnt_hi_we) cnt_d[15:8]  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  // R7
  cnt_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_lo_we || cnt_hi_we) |=> cnt_q <= $past(cnt_q));

  // R6
  end_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !sa_lo_we && !sa_hi_we && first_pg != end_pg)
      |=> addr_q != {{(AW-16){1'b0}}, $past(end_pg), 8'h00});
endmodule

// File: rtl/rdma_isr.sv
module rdma_isr
  import rdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_rdc,
  input  logic       cmd_we,
  input  logic       cmd_halt,
  input  logic       cmd_req,
  input  logic       cnt_zero,
  input  logic       stat_we,
  input  logic [6:0] clr_bits,
  input  logic [7:0] mask,
  output logic [7:0] stat_q,
  output logic       irq
);
  logic [7:0] stat_d;
  logic       zero_len;

  assign zero_len = cmd_we && !cmd_halt && cmd_req && cnt_zero;

  always_comb begin
    stat_d = stat_q;
    if (stat_we) stat_d[6:0] = stat_q[6:0] & ~clr_bits;
    if (cmd_we && !cmd_halt) stat_d[IS_RST] = 1'b0;
    if (set_rdc || zero_len) stat_d[IS_RDC] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 8'h80;
    else        stat_q <= stat_d;
  end

  assign irq = |(stat_q[6:0] & mask[6:0]);

  // R7
  rdc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_rdc |=> stat_q[IS_RDC]);

  // R10
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && clr_bits[IS_RDC] && !set_rdc && !zero_len) |=> !stat_q[IS_RDC]);

  // R1
  rst_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(stat_q[IS_RST]));
endmodule

// File: rtl/rdma_mem.sv
module rdma_mem #(
  parameter int WORDS = 2048,
  localparam int WA = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic [WA-1:0] idx,
  input  logic          we_lo,
  input  logic          we_hi,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata
);
  logic [15:0] ram [WORDS];

  always_ff @(posedge clk) begin
    if (we_lo) ram[idx][7:0]  <= wdata[7:0];
    if (we_hi) ram[idx][15:8] <= wdata[15:8];
  end

  assign rdata = ram[idx];
endmodule

// File: rtl/rdma_port.sv
module rdma_port
  import rdma_pkg::*;
#(
  parameter int            AW        = 16,
  parameter int            CW        = 16,
  parameter logic [AW-1:0] WIN_BASE  = 16'h4000,
  parameter int            WIN_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        dp_rd,
  input  logic        dp_wr,
  input  logic [15:0] dp_wdata,
  output logic [15:0] dp_rdata,
  output logic        irq
);
  localparam int WORDS = WIN_BYTES / 2;
  localparam int WA    = $clog2(WORDS);

  logic [1:0]    rs_q;
  logic          rst_ns;
  logic [7:0]    cmd_q, first_pg, end_pg, mask_q, stat_q;
  logic          word_mode, adv, done, in_win, lane;
  logic [AW-1:0] addr_q, eff, off;
  logic [CW-1:0] cnt_q;
  logic [15:0]   raw, mem_wd;
  logic          we_lo, we_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  rdma_cfg u_cfg (
    .clk(clk), .rst_n(rst_ns), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cmd_q(cmd_q), .first_pg_q(first_pg),
    .end_pg_q(end_pg), .mask_q(mask_q), .word_mode_q(word_mode)
  );

  assign eff    = word_mode ? {addr_q[AW-1:1], 1'b0} : addr_q;
  assign off    = eff - WIN_BASE;
  assign in_win = off < AW'(WIN_BYTES);
  assign lane   = off[0];
  assign adv    = dp_wr ? in_win : dp_rd;

  rdma_ptr #(.AW(AW), .CW(CW)) u_ptr (
    .clk(clk), .rst_n(rst_ns), .word_mode(word_mode), .adv(adv),
    .sa_lo_we(reg_we && reg_addr == RA_SA_LO),
    .sa_hi_we(reg_we && reg_addr == RA_SA_HI),
    .cnt_lo_we(reg_we && reg_addr == RA_CNT_LO),
    .cnt_hi_we(reg_we && reg_addr == RA_CNT_HI),
    .wdata(reg_wdata), .first_pg(first_pg), .end_pg(end_pg),
    .addr_q(addr_q), .cnt_q(cnt_q), .done(done)
  );

  rdma_isr u_isr (
    .clk(clk), .rst_n(rst_ns), .set_rdc(done),
    .cmd_we(reg_we && reg_addr == RA_CMD),
    .cmd_halt(reg_wdata[CMD_HALT]),
    .cmd_req(reg_wdata[CMD_RREQ] | reg_wdata[CMD_WREQ]),
    .cnt_zero(cnt_q == '0),
    .stat_we(reg_we && reg_addr == RA_INT_STAT),
    .clr_bits(reg_wdata[6:0]), .mask(mask_q), .stat_q(stat_q), .irq(irq)
  );

  assign mem_wd = word_mode ? dp_wdata : {dp_wdata[7:0], dp_wdata[7:0]};
  assign we_lo  = dp_wr && in_win && (word_mode || !lane);
  assign we_hi  = dp_wr && in_win && (word_mode || lane);

  rdma_mem #(.WORDS(WORDS)) u_mem (
    .clk(clk), .idx(off[WA:1]), .we_lo(we_lo), .we_hi(we_hi),
    .wdata(mem_wd), .rdata(raw)
  );

  always_comb begin
    if (!in_win)        dp_rdata = 16'hFFFF;
    else if (word_mode) dp_rdata = raw;
    else                dp_rdata = {8'h00, lane ? raw[15:8] : raw[7:0]};
  end

  always_comb begin
    case (reg_addr)
      RA_CMD:      reg_rdata = cmd_q;
      RA_SA_LO:    reg_rdata = addr_q[7:0];
      RA_SA_HI:    reg_rdata = addr_q[15:8];
      RA_CNT_LO:   reg_rdata = cnt_q[7:0];
      RA_CNT_HI:   reg_rdata = cnt_q[15:8];
      RA_PG_FIRST: reg_rdata = first_pg;
      RA_PG_END:   reg_rdata = end_pg;
      RA_INT_STAT: reg_rdata = stat_q;
      RA_INT_MASK: reg_rdata = mask_q;
      RA_DCFG:     reg_rdata = {7'd0, word_mode};
      default:     reg_rdata = 8'h00;
    endcase
  end

  // R9
  oow_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (dp_wr && !in_win && !reg_we) |=> ($stable(addr_q) && $stable(cnt_q)));
endmodule

// File: tb/rdma_port_bench.sv
module rdma_port_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        dp_rd = 1'b0, dp_wr = 1'b0;
  logic [15:0] dp_wdata = 16'h0;
  logic [15:0] dp_rdata;
  logic        irq;

  int n_tests = 0, n_fail = 0;
  bit started = 0, done_flag = 0;

  int m_cmd, m_addr, m_cnt, m_first, m_end, m_isr, m_imr, m_cfg;
  logic [7:0] m_mem [int];

  always #10 clk = ~clk;

  rdma_port u_rdma_port (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_rd(dp_rd),
    .dp_wr(dp_wr), .dp_wdata(dp_wdata), .dp_rdata(dp_rdata), .irq(irq)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int m_eff();
    return (m_cfg != 0) ? (m_addr & 'hFFFE) : m_addr;
  endfunction

  function automatic bit m_inwin();
    int e = m_eff();
    return (e >= 'h4000) && (e < 'h5000);
  endfunction

  function automatic void m_advance();
    int step = (m_cfg != 0) ? 2 : 1;
    m_addr = (m_addr + step) & 'hFFFF;
    if (m_addr == m_end * 256) m_addr = m_first * 256;
    if (m_cnt <= step) begin m_cnt = 0; m_isr |= 'h40; end
    else m_cnt -= step;
  endfunction

  function automatic int m_rd(int a);
    case (a)
      0: return m_cmd;
      1: return m_addr & 'hFF;
      2: return (m_addr >> 8) & 'hFF;
      3: return m_cnt & 'hFF;
      4: return (m_cnt >> 8) & 'hFF;
      5: return m_first;
      6: return m_end;
      7: return m_isr;
      8: return m_imr;
      9: return m_cfg;
      default: return 0;
    endcase
  endfunction

  task automatic wr_reg(int a, int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
    @(posedge clk); #1;
    case (a)
      0: begin
        m_cmd = d;
        if ((d & 1) == 0) begin
          m_isr &= 'h7F;
          if ((d & 6) != 0 && m_cnt == 0) m_isr |= 'h40;
        end
      end
      1: m_addr = (m_addr & 'hFF00) | d;
      2: m_addr = (m_addr & 'h00FF) | (d << 8);
      3: m_cnt = (m_cnt & 'hFF00) | d;
      4: m_cnt = (m_cnt & 'h00FF) | (d << 8);
      5: m_first = d;
      6: m_end = d;
      7: m_isr &= ~(d & 'h7F);
      8: m_imr = d;
      9: m_cfg = d & 1;
      default: ;
    endcase
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(string req, int a);
    @(negedge clk);
    reg_addr = 4'(a); #1;
    chk(req, {8'h00, reg_rdata}, 16'(m_rd(a)));
  endtask

  task automatic dp_write(int d);
    @(negedge clk);
    dp_wr = 1'b1; dp_wdata = 16'(d);
    @(posedge clk); #1;
    if (m_inwin()) begin
      if (m_cfg != 0) begin
        m_mem[m_eff()] = 8'(d); m_mem[m_eff() + 1] = 8'(d >> 8);
      end else m_mem[m_eff()] = 8'(d);
      m_advance();
    end
    dp_wr = 1'b0;
  endtask

  task automatic dp_read(string req);
    logic [15:0] e;
    @(negedge clk);
    dp_rd = 1'b1; #1;
    if (!m_inwin()) e = 16'hFFFF;
    else if (m_cfg != 0) e = {m_mem[m_eff() + 1], m_mem[m_eff()]};
    else e = {8'h00, m_mem[m_eff()]};
    chk(req, dp_rdata, e);
    @(posedge clk); #1;
    m_advance();
    dp_rd = 1'b0;
  endtask

  task automatic load_ptr(int a, int c);
    wr_reg(1, a & 'hFF); wr_reg(2, a >> 8);
    wr_reg(3, c & 'hFF); wr_reg(4, c >> 8);
  endtask

  // R11: interrupt line against the model on every clock
  always @(negedge clk) begin
    if (started && !done_flag)
      chk("R11 irq", {15'd0, irq}, {15'd0, ((m_isr & m_imr & 'h7F) != 0)});
  end

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_cmd = 0; m_addr = 0; m_cnt = 0; m_first = 0; m_end = 0;
    m_isr = 'h80; m_imr = 0; m_cfg = 0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    started = 1;

    // R1 reset state
    for (int a = 0; a < 10; a++) rd_reg("R1 reset", a);
    chk("R1 irq", {15'd0, irq}, 16'd0);

    // R10 bit 7 not cleared by a status write
    wr_reg(7, 'hFF); rd_reg("R10 bit7 kept", 7);
    wr_reg(8, 'hFF); rd_reg("R3 mask", 8);

    // R2 halt keeps bit 7, plain command clears it
    wr_reg(0, 'h01); rd_reg("R2 halt keeps", 7);
    wr_reg(0, 'h00); rd_reg("R2 clear", 7);

    // R4 R6 R7 byte mode across the ring end
    wr_reg(5, 'h40); wr_reg(6, 'h41); wr_reg(9, 0);
    rd_reg("R3 first page", 5); rd_reg("R3 end page", 6);
    load_ptr('h40FE, 4);
    rd_reg("R3 addr lo", 1); rd_reg("R3 addr hi", 2); rd_reg("R3 cnt lo", 3);
    dp_write('h11); dp_write('h22);
    rd_reg("R6 wrap lo", 1); rd_reg("R6 wrap hi", 2); rd_reg("R7 cnt", 3);
    dp_write('h33); rd_reg("R7 no flag yet", 7);
    dp_write('h44);
    rd_reg("R7 cnt zero", 3); rd_reg("R7 flag", 7);
    chk("R11 irq on done", {15'd0, irq}, 16'd1);
    wr_reg(7, 'h40); rd_reg("R10 w1c", 7);

    load_ptr('h40FE, 4);
    for (int i = 0; i < 4; i++) dp_read("R4 byte read");
    rd_reg("R6 addr after reads", 1);
    wr_reg(7, 'h40);

    // R5 word mode, odd start address
    wr_reg(9, 1);
    load_ptr('h4011, 3);
    dp_write('hBEEF);
    rd_reg("R5 addr step", 1); rd_reg("R7 cnt minus 2", 3);
    dp_write('h1234);
    rd_reg("R7 cnt zero word", 3); rd_reg("R7 flag word", 7);
    wr_reg(7, 'h40);
    wr_reg(9, 0); load_ptr('h4010, 8);
    for (int i = 0; i < 4; i++) dp_read("R5 little endian");
    wr_reg(9, 1); load_ptr('h4010, 8);
    dp_read("R5 word read"); dp_read("R5 word read");

    // R8 zero-length commands
    wr_reg(9, 0); load_ptr('h4000, 0);
    wr_reg(0, 'h02); rd_reg("R8 read req", 7);
    wr_reg(7, 'h40);
    wr_reg(0, 'h04); rd_reg("R8 write req", 7);
    wr_reg(7, 'h40);
    wr_reg(0, 'h00); rd_reg("R8 no req", 7);
    wr_reg(0, 'h03); rd_reg("R8 halted", 7);

    // R9 window edges
    load_ptr('h3FFF, 5);
    dp_read("R9 below window");
    rd_reg("R9 read adv lo", 1); rd_reg("R9 read adv hi", 2); rd_reg("R9 cnt", 3);
    load_ptr('h5000, 5);
    dp_read("R9 above window");
    load_ptr('h5000, 5);
    dp_write('h77);
    rd_reg("R9 wr hold lo", 1); rd_reg("R9 wr hold hi", 2); rd_reg("R9 wr hold cnt", 3);
    wr_reg(9, 1); load_ptr('h3FFF, 5);
    dp_write('hAAAA);
    rd_reg("R9 word hold", 1); rd_reg("R9 word cnt", 3);

    // R11 mask gating
    wr_reg(9, 0); load_ptr('h4000, 0);
    wr_reg(0, 'h02);
    wr_reg(8, 'h00); chk("R11 masked", {15'd0, irq}, 16'd0);
    wr_reg(8, 'h40); chk("R11 unmasked", {15'd0, irq}, 16'd1);
    wr_reg(8, 'hBF); chk("R11 other bits", {15'd0, irq}, 16'd0);

    repeat (2) @(negedge clk);
    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule